// File: doc/BRIEF.md
# Sv32 Page Fault Permission Checker

This block decides, in the same cycle, whether a translated memory access may go ahead or must trap with a page fault. It sits after the page table walker of a 32-bit core using two-level paging. The walker supplies a found flag and the permission bits of the leaf entry. The core supplies the kind of access, whether translation is on, and the privilege-related status fields: make-executable-readable, supervisor-user-access, modify-privilege and the previous privilege mode.

When the access is refused, the block raises a single fault strobe and gives the exception cause for the access kind. It also returns the virtual address as the trap value. When the access is allowed, the ok output is high and the cause and trap value are zero. With translation turned off, nothing faults and the permission bits have no effect.

Top module: `sv32_pf_checker`

## Requirements
- R1: The access kind is encoded 0 = fetch, 1 = load, 2 = store; code 3 is treated as a load. On a fault the cause is 12 for a fetch, 13 for a load (or code 3) and 15 for a store.
- R2: When translation is on and the walk reports no leaf (found low), the access faults, whatever the leaf bits are.
- R3: The leaf flag bits are bit 0 valid, bit 1 readable, bit 2 writable, bit 3 executable, bit 4 user. A found leaf with the valid bit clear faults for every access kind. So does a found leaf with the writable bit set and the readable bit clear.
- R4: A fetch faults when the leaf's executable bit is clear.
- R5: A load faults when the readable bit is clear. The exception is when make-executable-readable is set and the executable bit is set; that load is allowed.
- R6: A store faults when the leaf's writable bit is clear.
- R7: When modify-privilege is set and the previous mode is 2'b01 (supervisor), an access of any kind to a page with the user bit set faults unless supervisor-user-access is set. With any other previous mode, or with modify-privilege clear, the user bit and supervisor-user-access have no effect.
- R8: When translation is off, no fault is raised, for any input values.
- R9: On a fault the trap value equals the virtual address. Without a fault, cause and trap value are both zero. The ok output is always the inverse of the fault strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| xlate_en | input | 1 | Translation on (1) or bare mode (0) |
| walk_found | input | 1 | Walker returned a leaf entry |
| leaf_flags | input | 5 | Leaf flags {user, exec, write, read, valid} |
| acc_kind | input | 2 | Access kind: 0 fetch, 1 load, 2 store, 3 as load |
| st_mxr | input | 1 | Make-executable-readable status bit |
| st_sum | input | 1 | Supervisor-user-access status bit |
| st_mprv | input | 1 | Modify-privilege status bit |
| st_mpp | input | 2 | Previous privilege mode field |
| vaddr | input | 32 | Virtual address of the access |
| fault | output | 1 | Page fault strobe |
| ok | output | 1 | Access may proceed |
| cause | output | 4 | Exception cause code, zero when no fault |
| tval | output | 32 | Trap value, the virtual address on a fault |

## Verification
Several refusal reasons can apply to one access at once. One example is a leaf that is malformed and also blocks a user page. Another is a missing walk result that comes with leftover permission bits. A load refused on its readable bit can at the same moment be rescued by make-executable-readable. The sweep covers every combination of flags, access kinds and status bits, so these overlaps all occur. Each one is judged on three things: a single fault strobe, the cause chosen only by the access kind, and the trap value.

// File: rtl/sv32_pf_pkg.sv
package sv32_pf_pkg;

    typedef enum logic [1:0] {
        ACC_FETCH = 2'd0,
        ACC_LOAD  = 2'd1,
        ACC_STORE = 2'd2,
        ACC_RSVD  = 2'd3
    } acc_kind_e;

    localparam int FLG_V = 0;
    localparam int FLG_R = 1;
    localparam int FLG_W = 2;
    localparam int FLG_X = 3;
    localparam int FLG_U = 4;
    localparam int FLG_N = 5;

    localparam logic [1:0] MODE_SUPER = 2'b01;

    localparam int CODE_FETCH_PF = 12;
    localparam int CODE_LOAD_PF  = 13;
    localparam int CODE_STORE_PF = 15;

endpackage

// File: rtl/pf_cause_map.sv
module pf_cause_map
    import sv32_pf_pkg::*;
#(
    parameter int CAUSE_W = 4
) (
    input  acc_kind_e          kind,
    output logic [CAUSE_W-1:0] code
);
    always_comb begin
        unique case (kind)
            ACC_FETCH: code = CAUSE_W'(CODE_FETCH_PF);
            ACC_STORE: code = CAUSE_W'(CODE_STORE_PF);
            default:   code = CAUSE_W'(CODE_LOAD_PF);
        endcase
    end

    always_comb begin
        if (kind == ACC_STORE)
            p_store_code_r1: assert (code == CAUSE_W'(CODE_STORE_PF));
    end
endmodule

// File: rtl/pf_perm_eval.sv
module pf_perm_eval
    import sv32_pf_pkg::*;
(
    input  logic             found,
    input  acc_kind_e        kind,
    input  logic [FLG_N-1:0] flags,
    input  logic             mxr,
    input  logic             sum,
    input  logic             mprv,
    input  logic [1:0]       mpp,
    output logic             deny
);
    typedef struct packed {
        logic missing;
        logic malformed;
        logic exec_miss;
        logic read_miss;
        logic write_miss;
        logic user_block;
    } why_t;

    why_t why_d;

    always_comb begin
        why_d            = '0;
        why_d.missing    = !found;
        why_d.malformed  = !flags[FLG_V] || (flags[FLG_W] && !flags[FLG_R]);
        why_d.exec_miss  = (kind == ACC_FETCH) && !flags[FLG_X];
        why_d.read_miss  = ((kind == ACC_LOAD) || (kind == ACC_RSVD))
                           && !(flags[FLG_R] || (mxr && flags[FLG_X]));
        why_d.write_miss = (kind == ACC_STORE) && !flags[FLG_W];
        why_d.user_block = mprv && (mpp == MODE_SUPER) && flags[FLG_U] && !sum;
        deny             = |why_d;
    end

    always_comb begin
        if (!found)
            p_missing_denies_r2: assert (deny);
        if (found && !flags[FLG_V])
            p_invalid_denies_r3: assert (deny);
        if (kind == ACC_FETCH && !flags[FLG_X])
            p_fetch_noexec_r4: assert (deny);
        if (kind == ACC_STORE && !flags[FLG_W])
            p_store_nowrite_r6: assert (deny);
    end
endmodule

// File: rtl/sv32_pf_checker.sv
module sv32_pf_checker
    import sv32_pf_pkg::*;
#(
    parameter int VA_W    = 32,
    parameter int CAUSE_W = 4
) (
    input  logic               xlate_en,
    input  logic               walk_found,
    input  logic [4:0]         leaf_flags,
    input  logic [1:0]         acc_kind,
    input  logic               st_mxr,
    input  logic               st_sum,
    input  logic               st_mprv,
    input  logic [1:0]         st_mpp,
    input  logic [VA_W-1:0]    vaddr,
    output logic               fault,
    output logic               ok,
    output logic [CAUSE_W-1:0] cause,
    output logic [VA_W-1:0]    tval
);
    typedef struct packed {
        logic               fault;
        logic [CAUSE_W-1:0] cause;
        logic [VA_W-1:0]    tval;
    } verdict_t;

    acc_kind_e          kind;
    logic               deny;
    logic [CAUSE_W-1:0] kind_code;
    verdict_t           res_d;

    assign kind = acc_kind_e'(acc_kind);

    pf_perm_eval u_eval (
        .found (walk_found),
        .kind  (kind),
        .flags (leaf_flags),
        .mxr   (st_mxr),
        .sum   (st_sum),
        .mprv  (st_mprv),
        .mpp   (st_mpp),
        .deny  (deny)
    );

    pf_cause_map #(.CAUSE_W(CAUSE_W)) u_map (
        .kind (kind),
        .code (kind_code)
    );

    always_comb begin
        res_d       = '0;
        res_d.fault = xlate_en && deny;
        if (res_d.fault) begin
            res_d.cause = kind_code;
            res_d.tval  = vaddr;
        end
    end

    assign fault = res_d.fault;
    assign ok    = !res_d.fault;
    assign cause = res_d.cause;
    assign tval  = res_d.tval;

    always_comb begin
        if (!xlate_en)
            p_bare_no_fault_r8: assert (!fault);
        if (fault)
            p_cause_legal_r1: assert (cause == CAUSE_W'(CODE_FETCH_PF)
                                   || cause == CAUSE_W'(CODE_LOAD_PF)
                                   || cause == CAUSE_W'(CODE_STORE_PF));
        if (!fault)
            p_quiet_outputs_r9: assert (cause == '0 && tval == '0);
        p_ok_inverse_r9: assert (ok != fault);
    end
endmodule

// File: tb/sim_sv32_pf_checker.sv
`timescale 1ns/1ps
module sim_sv32_pf_checker;
    logic        clk = 1'b0;
    logic        xlate_en, walk_found, st_mxr, st_sum, st_mprv;
    logic [4:0]  leaf_flags;
    logic [1:0]  acc_kind, st_mpp;
    logic [31:0] vaddr;
    logic        fault, ok;
    logic [3:0]  cause;
    logic [31:0] tval;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    sv32_pf_checker u0 (
        .xlate_en(xlate_en), .walk_found(walk_found), .leaf_flags(leaf_flags),
        .acc_kind(acc_kind), .st_mxr(st_mxr), .st_sum(st_sum),
        .st_mprv(st_mprv), .st_mpp(st_mpp), .vaddr(vaddr),
        .fault(fault), .ok(ok), .cause(cause), .tval(tval)
    );

    task automatic check(input bit cond, input string tag,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!cond) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Reference model written from the requirements; returns the deciding tag
    function automatic string model(input bit xe, input bit fnd,
                                    input bit [4:0] fl, input bit [1:0] k,
                                    input bit mxr, input bit sm,
                                    input bit mprv, input bit [1:0] mpp,
                                    output bit flt, output bit [3:0] cc);
        bit v = fl[0], r = fl[1], w = fl[2], x = fl[3], u = fl[4];
        string tag = "R8";
        flt = 1'b0;
        if (xe) begin
            tag = "R7";
            if (!fnd) begin flt = 1; tag = "R2"; end
            else if (!v || (w && !r)) begin flt = 1; tag = "R3"; end
            else if (k == 2'd0 && !x) begin flt = 1; tag = "R4"; end
            else if ((k == 2'd1 || k == 2'd3) && !(r || (mxr && x))) begin flt = 1; tag = "R5"; end
            else if (k == 2'd2 && !w) begin flt = 1; tag = "R6"; end
            else if (mprv && mpp == 2'b01 && u && !sm) begin flt = 1; tag = "R7"; end
        end
        // R1: cause codes by access kind
        cc = !flt ? 4'd0 : (k == 2'd0) ? 4'd12 : (k == 2'd2) ? 4'd15 : 4'd13;
        return tag;
    endfunction

    initial begin
        bit        ef;
        bit [3:0]  ec;
        string     tg;
        int        idx = 0;
        xlate_en = 0; walk_found = 0; leaf_flags = 0; acc_kind = 0;
        st_mxr = 0; st_sum = 0; st_mprv = 0; st_mpp = 0; vaddr = 0;
        @(negedge clk);
        // reset/idle state: bare mode, all quiet
        check(!fault && ok && cause == 0 && tval == 0, "R8 idle", {31'd0, fault}, 0);

        for (int xe = 0; xe < 2; xe++)
        for (int fd = 0; fd < 2; fd++)
        for (int k = 0; k < 4; k++)
        for (int fl = 0; fl < 32; fl++)
        for (int st = 0; st < 8; st++)
        for (int mp = 0; mp < 4; mp++) begin
            @(posedge clk);
            xlate_en   = xe[0];
            walk_found = fd[0];
            acc_kind   = k[1:0];
            leaf_flags = fl[4:0];
            st_mxr     = st[0];
            st_sum     = st[1];
            st_mprv    = st[2];
            st_mpp     = mp[1:0];
            vaddr      = 32'(idx) * 32'h9E37_79B9 + 32'h1000;
            @(negedge clk);
            tg = model(xe[0], fd[0], fl[4:0], k[1:0], st[0], st[1], st[2],
                       mp[1:0], ef, ec);
            check(fault == ef, {tg, " fault"}, {31'd0, fault}, {31'd0, ef});
            check(cause == ec, {"R1 cause via ", tg}, {28'd0, cause}, {28'd0, ec});
            check(tval == (ef ? vaddr : 32'd0), "R9 tval", tval, ef ? vaddr : 32'd0);
            check(ok == !ef, "R9 ok", {31'd0, ok}, {31'd0, !ef});
            idx++;
        end
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (150000) @(posedge clk);
                checks++; errors++;
                $display("FAIL watchdog expired actual=running expected=done");
            end
        join_any
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule